// File: doc/BRIEF.md
# Paged Write Front End for a 2K x 8 Serial EEPROM

This block is the slave side of a two-wire serial memory, limited to writes. It watches oversampled clock and data lines from the bus, detects bus start and stop events, and checks the first byte of each transfer for the device code and a write direction. When that byte matches, the block drives the data line low to acknowledge. The next byte sets the low eight bits of an address pointer. Every byte after that is collected in a 16-entry page buffer.

The three block-select bits of the first byte become the top of an 11-bit memory address. The data bytes fill the page buffer at the pointer's low nibble. That nibble counts up and wraps inside the page, and the seven upper bits never change. Nothing reaches memory until a stop condition arrives with at least one byte held in the buffer. At that point the block raises `busy` for a fixed number of system clocks. While busy, it sends each received page entry to the memory write port, one per clock, in ascending offset order. During the busy window it acknowledges no first byte, even one whose code matches.

Top module: `ee_page_write_slave`

## Requirements
- R1: A first byte after a start is acknowledged only when its bits 7..4 equal 4'b1010 and its bit 0 is 0 (write). Any other code, or a bit 0 of 1 (read), gets no acknowledge, and the rest of the transfer is ignored.
- R2: Bits 3..1 of the accepted first byte appear as `mem_addr[10:8]` on every memory write of that transfer.
- R3: The acknowledge is asserted on `sda_oe` only during the ninth clock of an accepted byte. It rises while SCL is low after the eighth falling edge and is released after the ninth falling edge. `sda_oe` stays low while data bits are being received.
- R4: The second byte of a write transfer is acknowledged and loads address bits 7..0. The bytes after it are data.
- R5: Each data byte is acknowledged and stored at the pointer's low 4 bits, and only those 4 bits then increment. A transfer of up to 16 bytes writes each byte to `{block, addr[7:4], offset}`.
- R6: When more than 16 data bytes arrive, the offset wraps modulo 16 and later bytes replace earlier ones at the same offset. Exactly 16 memory writes result.
- R7: No memory write happens before the stop condition. After it, only the offsets received in this transfer are written, one per clock, in ascending offset order.
- R8: `busy` rises on the clock after a stop that ends a transfer carrying data, and stays high for exactly `WR_CYCLES` clocks. All memory writes fall inside that window.
- R9: While `busy` is high, no first byte is acknowledged, including a matching write code.
- R10: A repeated start, or a stop that arrives before any data byte, abandons the transfer with no memory write.
- R11: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high, both after two-flop synchronisation. After reset, `sda_oe`, `busy` and `mem_we` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| busy | output | 1 | High during the internal write cycle |
| mem_we | output | 1 | Memory write strobe, one byte per clock |
| mem_addr | output | 11 | Memory write address |
| mem_wdata | output | 8 | Memory write data |

## Verification
The assertions assume a legal bus. SDA changes only while SCL is low, except for start and stop events. Each SCL level is held for several system clocks, so that the two-flop synchroniser sees each edge as one clean transition. The bench meets this by holding every SCL phase for ten clocks and by changing its data line five clocks after each SCL fall. That gap is longer than the synchroniser delay plus the acknowledge release. Start and stop events are built only while SCL is high, with the data line already settled.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;
  localparam int ADDR_W     = 11;
  localparam int BLK_W      = 3;
  localparam int PAGE_BYTES = 16;
  localparam int OFF_W      = $clog2(PAGE_BYTES);
  localparam int HI_W       = ADDR_W - OFF_W;
  localparam logic [3:0] DEV_CODE = 4'b1010;

  typedef enum logic [1:0] {RX_IDLE, RX_BITS, RX_ACK, RX_SKIP} rx_state_t;
  typedef enum logic [1:0] {B_CTRL, B_ADDR, B_DATA} byte_kind_t;

  // True when a first byte should be acknowledged.
  function automatic logic ctrl_accepts(input logic [7:0] b, input logic busy);
    return (b[7:4] == DEV_CODE) && !b[0] && !busy;
  endfunction

  // Advance the pointer inside its page: only the offset moves.
  function automatic logic [ADDR_W-1:0] bump_ptr(input logic [ADDR_W-1:0] p);
    return {p[ADDR_W-1:OFF_W], p[OFF_W-1:0] + OFF_W'(1)};
  endfunction
endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        scl_pipe[g] <= 1'b1;
        sda_pipe[g] <= 1'b1;
      end else if (g == 0) begin
        scl_pipe[g] <= scl_i;
        sda_pipe[g] <= sda_i;
      end else begin
        scl_pipe[g] <= scl_pipe[(g == 0) ? 0 : g-1];
        sda_pipe[g] <= sda_pipe[(g == 0) ? 0 : g-1];
      end
    end
  end

  assign scl_s = scl_pipe[STAGES-1];
  assign sda_s = sda_pipe[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign start_ev = scl_s && scl_q && sda_q && !sda_s;
  assign stop_ev  = scl_s && scl_q && !sda_q && sda_s;
  assign scl_rise = scl_s && !scl_q;
  assign scl_fall = !scl_s && scl_q;
endmodule

// File: rtl/ee_rx_engine.sv
module ee_rx_engine
  import ee_wr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              busy_i,
  input  logic [OFF_W-1:0]  rd_idx,
  output logic              sda_oe,
  output logic              commit_go,
  output logic              ctrl_done,
  output logic [HI_W-1:0]   page_hi,
  output logic [PAGE_BYTES-1:0] valid_mask,
  output logic [7:0]        rd_data
);
  rx_state_t        st;
  byte_kind_t       kind;
  logic [7:0]       shreg;
  logic [3:0]       bit_cnt;
  logic [BLK_W-1:0] blk;
  logic [ADDR_W-1:0] ptr;
  logic [7:0]       page_buf [PAGE_BYTES];
  logic             byte_done;

  assign byte_done = (st == RX_BITS) && (bit_cnt == 4'd8) && scl_fall;
  assign ctrl_done = byte_done && (kind == B_CTRL);
  assign commit_go = stop_ev && (|valid_mask) && !busy_i;
  assign page_hi   = ptr[ADDR_W-1:OFF_W];
  assign rd_data   = page_buf[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= RX_IDLE;
      kind       <= B_CTRL;
      shreg      <= '0;
      bit_cnt    <= '0;
      blk        <= '0;
      ptr        <= '0;
      valid_mask <= '0;
      sda_oe     <= 1'b0;
      for (int i = 0; i < PAGE_BYTES; i++) page_buf[i] <= '0;
    end else if (start_ev) begin
      st         <= RX_BITS;
      kind       <= B_CTRL;
      bit_cnt    <= '0;
      valid_mask <= '0;
      sda_oe     <= 1'b0;
    end else if (stop_ev) begin
      st         <= RX_IDLE;
      valid_mask <= '0;
      sda_oe     <= 1'b0;
    end else begin
      case (st)
        RX_BITS: begin
          if (scl_rise && bit_cnt != 4'd8) begin
            shreg   <= {shreg[6:0], sda_s};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (byte_done) begin
            case (kind)
              B_CTRL: begin
                if (ctrl_accepts(shreg, busy_i)) begin
                  blk    <= shreg[BLK_W:1];
                  kind   <= B_ADDR;
                  sda_oe <= 1'b1;
                  st     <= RX_ACK;
                end else begin
                  st <= RX_SKIP;
                end
              end
              B_ADDR: begin
                ptr    <= {blk, shreg};
                kind   <= B_DATA;
                sda_oe <= 1'b1;
                st     <= RX_ACK;
              end
              default: begin
                page_buf[ptr[OFF_W-1:0]]   <= shreg;
                valid_mask[ptr[OFF_W-1:0]] <= 1'b1;
                ptr    <= bump_ptr(ptr);
                sda_oe <= 1'b1;
                st     <= RX_ACK;
              end
            endcase
          end
        end
        RX_ACK: begin
          if (scl_fall) begin
            sda_oe  <= 1'b0;
            st      <= RX_BITS;
            bit_cnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // Acknowledge only begins while the clock is low.
  assert_ack_on_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // A start clears every page-buffer valid flag.
  assert_mask_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_ev) |-> (valid_mask == '0));

  // Storing a data byte never moves the upper pointer bits.
  assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && kind == B_DATA) |=> (page_hi == $past(page_hi)));

  // A busy device never acknowledges a first byte.
  assert_silent_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_done && busy_i) |=> !sda_oe);
endmodule

// File: rtl/ee_commit_seq.sv
module ee_commit_seq
  import ee_wr_pkg::*;
#(
  parameter int WR_CYCLES = 64
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  commit_go,
  input  logic                  stop_ev,
  input  logic [HI_W-1:0]       page_hi,
  input  logic [PAGE_BYTES-1:0] mask_in,
  output logic                  busy,
  output logic [OFF_W-1:0]      rd_idx,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr
);
  localparam int TW = $clog2(WR_CYCLES + PAGE_BYTES + 1);

  logic [TW-1:0]         tick;
  logic [PAGE_BYTES-1:0] mask_q;
  logic [HI_W-1:0]       page_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      tick   <= '0;
      mask_q <= '0;
      page_q <= '0;
    end else if (commit_go) begin
      busy   <= 1'b1;
      tick   <= '0;
      mask_q <= mask_in;
      page_q <= page_hi;
    end else if (busy) begin
      if (tick == TW'(WR_CYCLES - 1)) busy <= 1'b0;
      tick <= tick + TW'(1);
    end
  end

  assign rd_idx   = tick[OFF_W-1:0];
  assign mem_we   = busy && (tick < TW'(PAGE_BYTES)) && mask_q[rd_idx];
  assign mem_addr = {page_q, rd_idx};

  // The write cycle is only ever launched by a stop event.
  assert_busy_after_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // Consecutive writes stay in one page.
  assert_one_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> (mem_addr[ADDR_W-1:OFF_W] == $past(mem_addr[ADDR_W-1:OFF_W])));
endmodule

// File: rtl/ee_page_write_slave.sv
module ee_page_write_slave
  import ee_wr_pkg::*;
#(
  parameter int WR_CYCLES   = 64,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  logic scl_s, sda_s, start_ev, stop_ev, scl_rise, scl_fall;
  logic commit_go, ctrl_done;
  logic [HI_W-1:0]       page_hi;
  logic [PAGE_BYTES-1:0] valid_mask;
  logic [OFF_W-1:0]      rd_idx;

  ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_ev(start_ev), .stop_ev(stop_ev),
    .scl_rise(scl_rise), .scl_fall(scl_fall));

  ee_rx_engine u_rx (
    .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_ev(start_ev),
    .stop_ev(stop_ev), .busy_i(busy), .rd_idx(rd_idx), .sda_oe(sda_oe),
    .commit_go(commit_go), .ctrl_done(ctrl_done), .page_hi(page_hi),
    .valid_mask(valid_mask), .rd_data(mem_wdata));

  ee_commit_seq #(.WR_CYCLES(WR_CYCLES)) u_commit (
    .clk(clk), .rst_n(rst_n), .commit_go(commit_go), .stop_ev(stop_ev),
    .page_hi(page_hi), .mask_in(valid_mask), .busy(busy), .rd_idx(rd_idx),
    .mem_we(mem_we), .mem_addr(mem_addr));

  // No write reaches memory while the bus is still acknowledging.
  assert_no_write_in_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !sda_oe);
endmodule

// File: tb/ee_page_write_slave_tb_top.sv
module ee_page_write_slave_tb_top;
  localparam int WR = 400;
  localparam int NV = 7;
  // {ctrl, addr, count, seed, expect_ack}
  localparam logic [30:0] VEC [NV] = '{
    {8'hA0, 8'h05, 6'd1,  8'h3C, 1'b1},
    {8'hA6, 8'hF0, 6'd16, 8'h10, 1'b1},
    {8'hAE, 8'hFA, 6'd20, 8'h80, 1'b1},
    {8'hB0, 8'h11, 6'd2,  8'h01, 1'b0},
    {8'hA1, 8'h22, 6'd2,  8'h02, 1'b0},
    {8'hA4, 8'h7E, 6'd3,  8'h55, 1'b1},
    {8'hA2, 8'h00, 6'd0,  8'h99, 1'b1}
  };

  logic clk = 1'b0, rst_n = 1'b0, scl = 1'b1, sda_drv = 1'b1;
  logic sda_oe, busy, mem_we;
  logic [10:0] mem_addr;
  logic [7:0] mem_wdata;
  wire sda_line = sda_drv & ~sda_oe;

  int checks = 0, fails = 0, wr_count = 0, oe_bits = 0;
  int busy_run = 0, last_busy = 0;
  bit done = 1'b0;
  logic [7:0] shadow [2048];
  logic [7:0] exp_mem [2048];

  always #10 clk = ~clk;

  ee_page_write_slave #(.WR_CYCLES(WR)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata));

  always @(posedge clk) begin
    if (mem_we) begin
      shadow[mem_addr] = mem_wdata;
      wr_count++;
    end
    if (busy) busy_run++;
    else if (busy_run != 0) begin
      last_busy = busy_run;
      busy_run = 0;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; scl = 1'b1; wait_clk(10);
    sda_drv = 1'b0; wait_clk(10);
    scl = 1'b0; wait_clk(5);
  endtask

  task automatic bus_restart();
    sda_drv = 1'b1; wait_clk(5);
    scl = 1'b1; wait_clk(10);
    sda_drv = 1'b0; wait_clk(10);
    scl = 1'b0; wait_clk(5);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; wait_clk(5);
    scl = 1'b1; wait_clk(10);
    sda_drv = 1'b1; wait_clk(10);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; wait_clk(5);
      scl = 1'b1; wait_clk(5);
      if (sda_oe) oe_bits++;
      wait_clk(5);
      scl = 1'b0; wait_clk(5);
    end
    sda_drv = 1'b1; wait_clk(5);
    scl = 1'b1; wait_clk(5);
    ack = sda_oe;
    wait_clk(5);
    scl = 1'b0; wait_clk(5);
  endtask

  task automatic wait_idle();
    wait_clk(4);
    while (busy) wait_clk(1);
    wait_clk(3);
  endtask

  function automatic int mismatches();
    int m = 0;
    for (int i = 0; i < 2048; i++) if (shadow[i] !== exp_mem[i]) m++;
    return m;
  endfunction

  task automatic run_vec(input logic [7:0] c, input logic [7:0] a, input int n,
                         input logic [7:0] seed, input bit eack);
    bit ak;
    int nacks = 0, nw;
    wr_count = 0; oe_bits = 0; last_busy = 0;
    bus_start();
    send_byte(c, ak);
    check(ak == eack, "R1 control acknowledge", ak, eack);
    if (ak) begin
      send_byte(a, ak);
      check(ak == 1'b1, "R4 address acknowledge", ak, 1);
      for (int k = 0; k < n; k++) begin
        send_byte(8'(seed + k), ak);
        if (!ak) nacks++;
      end
      check(nacks == 0, "R5 data acknowledges", nacks, 0);
      check(wr_count == 0, "R7 no write before stop", wr_count, 0);
    end
    bus_stop();
    wait_idle();
    if (eack) begin
      for (int k = 0; k < n; k++)
        exp_mem[{c[3:1], a[7:4], 4'(a[3:0] + k)}] = 8'(seed + k);
    end
    nw = (eack && n > 0) ? ((n > 16) ? 16 : n) : 0;
    if (n > 16) check(wr_count == nw, "R6 wrapped write count", wr_count, nw);
    else        check(wr_count == nw, "R5 write count", wr_count, nw);
    check(mismatches() == 0, "R2 memory contents", mismatches(), 0);
    check(oe_bits == 0, "R3 no drive during data bits", oe_bits, 0);
    if (nw > 0) check(last_busy == WR, "R8 busy length", last_busy, WR);
    else        check(last_busy == 0, "R10 no write cycle", last_busy, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    bit ak;
    for (int i = 0; i < 2048; i++) begin
      shadow[i] = 8'h00;
      exp_mem[i] = 8'h00;
    end
    wait_clk(5);
    check(sda_oe == 1'b0, "R11 reset sda_oe", sda_oe, 0);
    check(busy == 1'b0, "R11 reset busy", busy, 0);
    check(mem_we == 1'b0, "R11 reset mem_we", mem_we, 0);
    rst_n = 1'b1;
    wait_clk(5);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][30:23], VEC[v][22:15], int'(VEC[v][14:9]), VEC[v][8:1], VEC[v][0]);

    // R2: block 3, address F0 holds the first byte of vector 1
    check(shadow[11'h3F0] == 8'h10, "R2 block bits on address", shadow[11'h3F0], 8'h10);
    // R6: wrapped offsets 10..13 of block 7 page F hold the later bytes
    check(shadow[11'h7FA] == 8'h90, "R6 overwrite at offset A", shadow[11'h7FA], 8'h90);

    // R9: a matching control byte during the write cycle is not acknowledged
    wr_count = 0;
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h40, ak); send_byte(8'h5A, ak);
    bus_stop();
    exp_mem[11'h040] = 8'h5A;
    wait_clk(3);
    check(busy == 1'b1, "R8 busy after stop", busy, 1);
    bus_start(); send_byte(8'hA0, ak);
    check(ak == 1'b0, "R9 silent while busy", ak, 0);
    bus_stop();
    wait_idle();
    check(wr_count == 1, "R9 single write", wr_count, 1);
    check(mismatches() == 0, "R9 memory contents", mismatches(), 0);

    // R10: repeated start abandons buffered bytes
    wr_count = 0;
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h20, ak);
    send_byte(8'h11, ak); send_byte(8'h22, ak);
    bus_restart();
    bus_stop();
    wait_idle();
    check(wr_count == 0, "R10 repeated start aborts", wr_count, 0);

    // R10: repeated start followed by a fresh write keeps only the new byte
    wr_count = 0;
    bus_start(); send_byte(8'hA0, ak); send_byte(8'h60, ak);
    send_byte(8'h33, ak); send_byte(8'h44, ak);
    bus_restart(); send_byte(8'hA2, ak); send_byte(8'h65, ak); send_byte(8'h77, ak);
    bus_stop();
    wait_idle();
    exp_mem[11'h165] = 8'h77;
    check(wr_count == 1, "R10 only new transfer written", wr_count, 1);
    check(mismatches() == 0, "R10 memory contents", mismatches(), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule